// File: doc/BRIEF.md
# Indexed Register Access Front End for an Interrupt Redirection Unit

This block is the software-facing register slave of an interrupt redirection unit. A narrow memory-mapped window of four offsets gives access to a much larger register space. Software first loads an 8-bit selector into the index register. It then reads or writes the 32-bit data port, which reaches the register that the selector names: an identification word, a read-only version word, or one half of a 64-bit redirection entry. There is one redirection entry for each interrupt input.

The block stores the fields of every entry that software may write and presents them as flat configuration vectors to the trigger and delivery logic beside it. It does not store the two status bits that the trigger logic owns, the in-flight flag and the awaiting-EOI flag. Those come in on input pins and are merged into the read data. Writes to the two write-only offsets are not stored. Each one is passed on as a one-cycle pulse with its payload: an interrupt-input number for a message-signalled pin assertion, or an interrupt vector for an end-of-interrupt notice.

Every access takes a single cycle. An access is a valid/write/address/data strobe. Read data is registered and appears in the cycle after the read is accepted.

Top module: `idxreg_front`

## Requirements
- R1: The index register sits at offset 00h. A write stores `bus_wdata[7:0]`, and a read returns that value zero-extended to 32 bits.
- R2: `bus_rdata` updates one cycle after an accepted read and holds its value otherwise. Reads of the data port at offset 10h return the register that the current index selects. Reads of offsets 20h and 40h, and of any unmapped offset, return zero.
- R3: Index 00h selects a 32-bit identification register that software can read and write in full.
- R4: Index 01h selects a read-only version word. Its layout is: implementation version in bits 7:0, a pin-assertion-port flag of 1 in bit 15, and the entry count minus one in bits 23:16. All other bits are zero. Writes to it have no effect.
- R5: Indices 02h–0Fh, and indices from 10h+2·NUM_ENT up to FFh, read as zero. Writes to them change no stored state.
- R6: Entry n's low word is at index 10h+2n. The writable bits are: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, trigger mode 15 and mask 16. They read back as written, appear on the matching `cfg_*` outputs, and leave every other entry unchanged.
- R7: Entry n's high word is at index 11h+2n. Only destination bits 31:24 are stored and read back; bits 23:0 read as zero.
- R8: Bit 12 of a low word reads `hw_busy[n]` and bit 14 reads `hw_rirr[n]`. Software writes to those two bit positions are ignored.
- R9: After reset every entry has its mask bit set and all other entry fields at zero. The index and the identification register are zero, and no pulse is active.
- R10: A write to offset 20h produces `pin_pulse` high for exactly one cycle, in the cycle after the write. `pin_num` carries `bus_wdata[PIN_W-1:0]` and the upper data bits are ignored.
- R11: A write to offset 40h produces `eoi_pulse` high for exactly one cycle, in the cycle after the write, with `eoi_vec` equal to `bus_wdata[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_busy | input | NUM_ENT | In-flight status from the trigger logic, one bit per entry |
| hw_rirr | input | NUM_ENT | Awaiting-EOI status from the trigger logic, one bit per entry |
| cfg_vec | output | 8·NUM_ENT | Vector field of each entry |
| cfg_dlv | output | 3·NUM_ENT | Delivery mode field of each entry |
| cfg_dmode | output | NUM_ENT | Destination mode bit of each entry |
| cfg_pol | output | NUM_ENT | Polarity bit of each entry |
| cfg_trig | output | NUM_ENT | Trigger mode bit of each entry |
| cfg_mask | output | NUM_ENT | Mask bit of each entry |
| cfg_dest | output | 8·NUM_ENT | Destination field of each entry |
| pin_pulse | output | 1 | One-cycle pin-assertion event |
| pin_num | output | PIN_W | Input number carried with pin_pulse |
| eoi_pulse | output | 1 | One-cycle end-of-interrupt event |
| eoi_vec | output | 8 | Vector carried with eoi_pulse |

## Verification
The bench targets the index arithmetic at its edges: the first and last entries, the index just past the last entry, and the reserved range 02h–0Fh. An off-by-one in the decode would either alias a reserved index onto an entry or drop the top entry's high word. Writes of all ones show whether the hardware-owned status bits or the reserved bits can be written; a design that masked them wrongly would read back 1s there or corrupt the configuration outputs. The status inputs are toggled between reads of the same word to catch a design that latched them instead of reflecting them. Back-to-back checks of the pulse outputs catch pulses that stretch beyond one cycle or that carry the unused upper data bits.

// File: rtl/idxreg_pkg.sv
package idxreg_pkg;

  localparam logic [7:0] OFS_INDEX = 8'h00;
  localparam logic [7:0] OFS_DATA  = 8'h10;
  localparam logic [7:0] OFS_PIN   = 8'h20;
  localparam logic [7:0] OFS_EOI   = 8'h40;

  localparam logic [7:0] SEL_ID    = 8'h00;
  localparam logic [7:0] SEL_VER   = 8'h01;
  localparam logic [7:0] SEL_TBL   = 8'h10;

  // Stored (software-writable) fields of one redirection entry
  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       trig;
    logic       pol;
    logic       dmode;
    logic [2:0] dlv;
    logic [7:0] vec;
  } ent_cfg_t;

  localparam ent_cfg_t ENT_RESET = '{dest: 8'd0, mask: 1'b1, trig: 1'b0,
                                     pol: 1'b0, dmode: 1'b0, dlv: 3'd0,
                                     vec: 8'd0};

  // Low word of an entry with hardware-owned status merged in
  function automatic logic [31:0] pack_lo(ent_cfg_t c, logic rirr, logic busy);
    return {15'd0, c.mask, c.trig, rirr, c.pol, busy, c.dmode, c.dlv, c.vec};
  endfunction

  // High word of an entry
  function automatic logic [31:0] pack_hi(ent_cfg_t c);
    return {c.dest, 24'd0};
  endfunction

  // Convert a data-port write word into entry fields (both halves)
  function automatic ent_cfg_t unpack_wr(logic [31:0] w);
    ent_cfg_t c;
    c.dest  = w[31:24];
    c.mask  = w[16];
    c.trig  = w[15];
    c.pol   = w[13];
    c.dmode = w[11];
    c.dlv   = w[10:8];
    c.vec   = w[7:0];
    return c;
  endfunction

  // Version word
  function automatic logic [31:0] ver_word(logic [7:0] ver, int unsigned n);
    logic [7:0] last;
    last = 8'(n - 1);
    return {8'd0, last, 1'b1, 7'd0, ver};
  endfunction

  // Index of the low word of entry k
  function automatic logic [7:0] lo_index(int unsigned k);
    return 8'(32'(SEL_TBL) + 2 * k);
  endfunction

endpackage

// File: rtl/idxreg_decode.sv
module idxreg_decode
  import idxreg_pkg::*;
(
  input  logic       bus_valid,
  input  logic       bus_write,
  input  logic [7:0] bus_addr,
  output logic       wr_index,
  output logic       wr_data,
  output logic       wr_pin,
  output logic       wr_eoi,
  output logic       rd_any
);

  logic do_wr;

  always_comb begin
    do_wr    = bus_valid && bus_write;
    wr_index = do_wr && (bus_addr == OFS_INDEX);
    wr_data  = do_wr && (bus_addr == OFS_DATA);
    wr_pin   = do_wr && (bus_addr == OFS_PIN);
    wr_eoi   = do_wr && (bus_addr == OFS_EOI);
    rd_any   = bus_valid && !bus_write;
  end

endmodule

// File: rtl/idxreg_entry.sv
module idxreg_entry
  import idxreg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_lo,
  input  logic     wr_hi,
  input  ent_cfg_t wr_val,
  output ent_cfg_t cfg
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= ENT_RESET;
    end else begin
      if (wr_lo) begin
        cfg.mask  <= wr_val.mask;
        cfg.trig  <= wr_val.trig;
        cfg.pol   <= wr_val.pol;
        cfg.dmode <= wr_val.dmode;
        cfg.dlv   <= wr_val.dlv;
        cfg.vec   <= wr_val.vec;
      end
      if (wr_hi) begin
        cfg.dest <= wr_val.dest;
      end
    end
  end

endmodule

// File: rtl/idxreg_rdmux.sv
module idxreg_rdmux
  import idxreg_pkg::*;
#(
  parameter int unsigned NUM_ENT = 24,
  parameter logic [7:0]  VERSION = 8'h20
) (
  input  logic [7:0]               bus_addr,
  input  logic [7:0]               idx,
  input  logic [31:0]              id_word,
  input  ent_cfg_t [NUM_ENT-1:0]   cfgs,
  input  logic [NUM_ENT-1:0]       hw_busy,
  input  logic [NUM_ENT-1:0]       hw_rirr,
  output logic [31:0]              rd_word
);

  logic [31:0] ind_word;

  always_comb begin
    ind_word = 32'd0;
    if (idx == SEL_ID)  ind_word = id_word;
    if (idx == SEL_VER) ind_word = ver_word(VERSION, NUM_ENT);
    for (int k = 0; k < int'(NUM_ENT); k++) begin
      if (idx == lo_index(k))
        ind_word = pack_lo(cfgs[k], hw_rirr[k], hw_busy[k]);
      if (idx == lo_index(k) + 8'd1)
        ind_word = pack_hi(cfgs[k]);
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_INDEX: rd_word = {24'd0, idx};
      OFS_DATA:  rd_word = ind_word;
      default:   rd_word = 32'd0;
    endcase
  end

endmodule

// File: rtl/idxreg_front.sv
module idxreg_front
  import idxreg_pkg::*;
#(
  parameter int unsigned NUM_ENT = 24,
  parameter logic [7:0]  VERSION = 8'h20,
  parameter int unsigned PIN_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_ENT-1:0]   hw_busy,
  input  logic [NUM_ENT-1:0]   hw_rirr,
  output logic [8*NUM_ENT-1:0] cfg_vec,
  output logic [3*NUM_ENT-1:0] cfg_dlv,
  output logic [NUM_ENT-1:0]   cfg_dmode,
  output logic [NUM_ENT-1:0]   cfg_pol,
  output logic [NUM_ENT-1:0]   cfg_trig,
  output logic [NUM_ENT-1:0]   cfg_mask,
  output logic [8*NUM_ENT-1:0] cfg_dest,
  output logic                 pin_pulse,
  output logic [PIN_W-1:0]     pin_num,
  output logic                 eoi_pulse,
  output logic [7:0]           eoi_vec
);

  // Named internal events, visible to the bound checker
  logic        wr_index_ev, wr_data_ev, wr_pin_ev, wr_eoi_ev, rd_ev;
  logic [7:0]  idx_q;
  logic [31:0] id_q;
  logic [31:0] rd_word;
  ent_cfg_t    wr_val;
  ent_cfg_t [NUM_ENT-1:0] cfgs;

  idxreg_decode u_dec (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .wr_index  (wr_index_ev),
    .wr_data   (wr_data_ev),
    .wr_pin    (wr_pin_ev),
    .wr_eoi    (wr_eoi_ev),
    .rd_any    (rd_ev)
  );

  assign wr_val = unpack_wr(bus_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'd0;
      id_q  <= 32'd0;
    end else begin
      if (wr_index_ev) idx_q <= bus_wdata[7:0];
      if (wr_data_ev && idx_q == SEL_ID) id_q <= bus_wdata;
    end
  end

  for (genvar k = 0; k < int'(NUM_ENT); k++) begin : g_ent
    logic hit_lo, hit_hi;
    assign hit_lo = wr_data_ev && (idx_q == lo_index(k));
    assign hit_hi = wr_data_ev && (idx_q == lo_index(k) + 8'd1);

    idxreg_entry u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_lo  (hit_lo),
      .wr_hi  (hit_hi),
      .wr_val (wr_val),
      .cfg    (cfgs[k])
    );

    assign cfg_vec[8*k +: 8]  = cfgs[k].vec;
    assign cfg_dlv[3*k +: 3]  = cfgs[k].dlv;
    assign cfg_dmode[k]       = cfgs[k].dmode;
    assign cfg_pol[k]         = cfgs[k].pol;
    assign cfg_trig[k]        = cfgs[k].trig;
    assign cfg_mask[k]        = cfgs[k].mask;
    assign cfg_dest[8*k +: 8] = cfgs[k].dest;
  end

  idxreg_rdmux #(.NUM_ENT(NUM_ENT), .VERSION(VERSION)) u_rd (
    .bus_addr (bus_addr),
    .idx      (idx_q),
    .id_word  (id_q),
    .cfgs     (cfgs),
    .hw_busy  (hw_busy),
    .hw_rirr  (hw_rirr),
    .rd_word  (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= 32'd0;
      pin_pulse <= 1'b0;
      pin_num   <= '0;
      eoi_pulse <= 1'b0;
      eoi_vec   <= 8'd0;
    end else begin
      if (rd_ev) bus_rdata <= rd_word;
      pin_pulse <= wr_pin_ev;
      eoi_pulse <= wr_eoi_ev;
      if (wr_pin_ev) pin_num <= bus_wdata[PIN_W-1:0];
      if (wr_eoi_ev) eoi_vec <= bus_wdata[7:0];
    end
  end

endmodule

// File: rtl/idxreg_front_chk.sv
module idxreg_front_chk #(
  parameter int unsigned NUM_ENT = 24,
  parameter int unsigned PIN_W   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [7:0]           bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_ENT-1:0]   cfg_mask,
  input logic [8*NUM_ENT-1:0] cfg_vec,
  input logic [8*NUM_ENT-1:0] cfg_dest,
  input logic                 pin_pulse,
  input logic [PIN_W-1:0]     pin_num,
  input logic                 eoi_pulse,
  input logic [7:0]           eoi_vec,
  input logic [7:0]           idx_q,
  input logic                 wr_data_ev,
  input logic                 rd_ev
);

  // R1
  index_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && bus_addr == 8'h00) |=> (bus_rdata == {24'd0, $past(idx_q)}));

  // R2
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(bus_rdata));

  // R5
  reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data_ev && idx_q >= 8'h02 && idx_q <= 8'h0F) |=>
      (cfg_mask == $past(cfg_mask) && cfg_vec == $past(cfg_vec) &&
       cfg_dest == $past(cfg_dest)));

  // R9
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&cfg_mask && !pin_pulse && !eoi_pulse));

  // R10
  pin_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 8'h20) |=>
      (pin_pulse && pin_num == $past(bus_wdata[PIN_W-1:0])));

  // R10
  pin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pulse |-> $past(bus_valid && bus_write && bus_addr == 8'h20));

  // R11
  eoi_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == 8'h40) |=>
      (eoi_pulse && eoi_vec == $past(bus_wdata[7:0])));

  // R11
  eoi_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_pulse |-> $past(bus_valid && bus_write && bus_addr == 8'h40));

endmodule

bind idxreg_front idxreg_front_chk #(.NUM_ENT(NUM_ENT), .PIN_W(PIN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .cfg_mask   (cfg_mask),
  .cfg_vec    (cfg_vec),
  .cfg_dest   (cfg_dest),
  .pin_pulse  (pin_pulse),
  .pin_num    (pin_num),
  .eoi_pulse  (eoi_pulse),
  .eoi_vec    (eoi_vec),
  .idx_q      (idx_q),
  .wr_data_ev (wr_data_ev),
  .rd_ev      (rd_ev)
);

// File: tb/idxreg_front_bench.sv
`timescale 1ns/1ps
module idxreg_front_bench;

  localparam int N     = 24;
  localparam int PIN_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic [N-1:0] hw_busy = '0, hw_rirr = '0;
  logic [8*N-1:0] cfg_vec, cfg_dest;
  logic [3*N-1:0] cfg_dlv;
  logic [N-1:0] cfg_dmode, cfg_pol, cfg_trig, cfg_mask;
  logic pin_pulse, eoi_pulse;
  logic [PIN_W-1:0] pin_num;
  logic [7:0] eoi_vec;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  idxreg_front #(.NUM_ENT(N), .VERSION(8'h20), .PIN_W(PIN_W)) u_idxreg_front (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_busy(hw_busy), .hw_rirr(hw_rirr), .cfg_vec(cfg_vec), .cfg_dlv(cfg_dlv),
    .cfg_dmode(cfg_dmode), .cfg_pol(cfg_pol), .cfg_trig(cfg_trig),
    .cfg_mask(cfg_mask), .cfg_dest(cfg_dest), .pin_pulse(pin_pulse),
    .pin_num(pin_num), .eoi_pulse(eoi_pulse), .eoi_vec(eoi_vec)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ind_rd(logic [7:0] idx, output logic [31:0] d);
    bus_wr(8'h00, {24'd0, idx});
    bus_rd(8'h10, d);
  endtask

  task automatic ind_wr(logic [7:0] idx, logic [31:0] d);
    bus_wr(8'h00, {24'd0, idx});
    bus_wr(8'h10, d);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    check("R9 mask", {8'd0, cfg_mask}, {8'd0, {N{1'b1}}});
    check("R9 vec zero", 32'(cfg_vec == '0), 32'd1);
    check("R9 dest zero", 32'(cfg_dest == '0), 32'd1);
    check("R9 pulses", {30'd0, pin_pulse, eoi_pulse}, 32'd0);
    bus_rd(8'h00, r); check("R9 index", r, 32'd0);
    bus_rd(8'h10, r); check("R9 id", r, 32'd0);
    ind_rd(8'h10, r); check("R9 entry0 lo", r, 32'h0001_0000);
  endtask

  task automatic t_index();
    logic [31:0] r;
    bus_wr(8'h00, 32'h0000_005A);
    bus_rd(8'h00, r); check("R1 index", r, 32'h5A);
    bus_wr(8'h00, 32'h1234_56A5);
    bus_rd(8'h00, r); check("R1 index low byte", r, 32'hA5);
    bus_rd(8'h20, r); check("R2 pin offset reads 0", r, 32'd0);
    bus_rd(8'h40, r); check("R2 eoi offset reads 0", r, 32'd0);
    bus_rd(8'h30, r); check("R2 unmapped reads 0", r, 32'd0);
    @(negedge clk); @(negedge clk);
    check("R2 hold", bus_rdata, 32'd0);
  endtask

  task automatic t_id();
    logic [31:0] r;
    ind_wr(8'h00, 32'hDEAD_BEEF);
    ind_rd(8'h00, r); check("R3 id", r, 32'hDEAD_BEEF);
  endtask

  task automatic t_version();
    logic [31:0] r;
    ind_rd(8'h01, r); check("R4 version", r, 32'h0017_8020);
    ind_wr(8'h01, 32'h0000_0000);
    ind_rd(8'h01, r); check("R4 version ro", r, 32'h0017_8020);
  endtask

  task automatic t_entry();
    logic [31:0] r;
    ind_wr(8'h14, 32'hFFFF_FFFF);
    ind_rd(8'h14, r); check("R6 entry2 all ones", r, 32'h0001_AFFF);
    check("R6 vec2", {24'd0, cfg_vec[16 +: 8]}, 32'hFF);
    check("R6 dlv2", {29'd0, cfg_dlv[6 +: 3]}, 32'd7);
    ind_wr(8'h14, 32'h0000_A820);
    ind_rd(8'h14, r); check("R6 entry2 lo", r, 32'h0000_A820);
    check("R6 flags2", {28'd0, cfg_mask[2], cfg_trig[2], cfg_pol[2], cfg_dmode[2]}, 32'b0111);
    check("R6 neighbours", {29'd0, cfg_mask[1], cfg_mask[3], cfg_trig[3]}, 32'b110);
    ind_wr(8'h15, 32'h23FF_FFFF);
    ind_rd(8'h15, r); check("R7 entry2 hi", r, 32'h2300_0000);
    check("R7 dest2", {24'd0, cfg_dest[16 +: 8]}, 32'h23);
    ind_wr(8'h3F, 32'h8100_0000);
    ind_rd(8'h3F, r); check("R7 last hi", r, 32'h8100_0000);
    check("R7 dest23", {24'd0, cfg_dest[184 +: 8]}, 32'h81);
    ind_wr(8'h3E, 32'h0000_0031);
    check("R6 last vec", {24'd0, cfg_vec[184 +: 8]}, 32'h31);
    check("R6 last mask", {31'd0, cfg_mask[23]}, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] r;
    hw_busy[2] = 1'b1; hw_rirr[2] = 1'b1;
    ind_rd(8'h14, r); check("R8 status on", r, 32'h0000_F820);
    ind_wr(8'h14, 32'h0000_5020);
    ind_rd(8'h14, r); check("R8 write ignored, hw on", r, 32'h0000_5020);
    hw_busy[2] = 1'b0; hw_rirr[2] = 1'b0;
    ind_rd(8'h14, r); check("R8 status follows hw", r, 32'h0000_0020);
  endtask

  task automatic t_reserved();
    logic [31:0] r;
    logic [N-1:0]   m0;
    logic [8*N-1:0] v0, d0;
    m0 = cfg_mask; v0 = cfg_vec; d0 = cfg_dest;
    ind_wr(8'h05, 32'hFFFF_FFFF);
    ind_rd(8'h05, r); check("R5 idx 05", r, 32'd0);
    ind_wr(8'h0F, 32'hFFFF_FFFF);
    ind_rd(8'h0F, r); check("R5 idx 0F", r, 32'd0);
    ind_wr(8'h40, 32'hFFFF_FFFF);
    ind_rd(8'h40, r); check("R5 idx past end", r, 32'd0);
    ind_wr(8'hFF, 32'hFFFF_FFFF);
    ind_rd(8'hFF, r); check("R5 idx FF", r, 32'd0);
    check("R5 mask untouched", 32'(cfg_mask == m0), 32'd1);
    check("R5 vec untouched", 32'(cfg_vec == v0), 32'd1);
    check("R5 dest untouched", 32'(cfg_dest == d0), 32'd1);
    ind_rd(8'h00, r); check("R5 id untouched", r, 32'hDEAD_BEEF);
  endtask

  task automatic t_pin();
    bus_wr(8'h20, 32'hFFFF_FFE5);
    check("R10 pulse", {31'd0, pin_pulse}, 32'd1);
    check("R10 num", {27'd0, pin_num}, 32'h05);
    check("R10 no eoi", {31'd0, eoi_pulse}, 32'd0);
    @(negedge clk);
    check("R10 one cycle", {31'd0, pin_pulse}, 32'd0);
  endtask

  task automatic t_eoi();
    bus_wr(8'h40, 32'h0000_0131);
    check("R11 pulse", {31'd0, eoi_pulse}, 32'd1);
    check("R11 vec", {24'd0, eoi_vec}, 32'h31);
    @(negedge clk);
    check("R11 one cycle", {31'd0, eoi_pulse}, 32'd0);
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_index();
    t_id();
    t_version();
    t_entry();
    t_status();
    t_reserved();
    t_pin();
    t_eoi();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule